// File: doc/BRIEF.md
# Boundary Scan I/O Data Register

This block is the data-register half of a boundary-scan port for a small array of programmable I/O pins. It is one serial chain of scan bits. Each bit has a shift flip-flop, a multiplexer that picks between the serial neighbour and a parallel capture value, and an update latch behind the flip-flop. A one-bit bypass register runs beside the chain, and an output multiplexer chooses which of the two drives the serial output. The tap controller and the instruction decoder are not part of the block. Their decisions arrive as plain control inputs: a data-register strobe, a shift/capture select, an update strobe, an external-test mode select and a bypass select.

The chain is not a uniform row of cells. Every pin is one of three kinds, and its kind sets how many bits it adds:
- A bidirectional pin adds three bits.
- An output-only pin adds three bits.
- An input-only pin adds one bit.

Two bits that capture internal signals sit at the serial-output end of the chain. A bit whose update latch drives an internal net sits at the serial-input end. All pins of one kind are grouped together, in the order bidirectional, input-only, output-only, and the counts of each kind are parameters.

Top module: `bsr_chain`

## Requirements
- R1: A synchronous active-high reset clears every shift flip-flop, every update latch and the bypass bit. Afterwards, in external-test mode, every `pad_oe` is 0 (0 means high impedance), `int_net` is 0 and `tdo` is 0.
- R2: The chain length is 2 + 3·N_BIDIR + N_INONLY + 3·N_OUTONLY + 1. Bit 0 is the bit nearest `tdo`.
  - Bit 0 captures `cap_t` and bit 1 captures `cap_o`.
  - The pins follow in index order. A three-bit pin holds its input bit at the lowest position, then its output bit, then its drive-enable bit. An input-only pin holds only its input bit.
  - The last bit is the internally driven bit.
- R3: On `dr_strobe` with `shift_sel`=0, the chain loads in one cycle:
  - every input bit takes `pad_i`;
  - every output bit takes `core_o`;
  - every enable bit takes `core_oe`;
  - bit 0 takes `cap_t` and bit 1 takes `cap_o`;
  - the last bit takes the current `int_net`.
- R4: On `dr_strobe` with `shift_sel`=1, every bit moves one position toward bit 0 and the last bit takes `tdi`. With `byp_sel`=0, `tdo` shows bit 0.
- R5: On `upd_strobe`, every update latch loads its shift flip-flop's value from before that edge, even when a shift happens in the same cycle. `int_net` shows the last bit's latch.
- R6: Without `upd_strobe`, the update latches hold. In external-test mode, `pad_o` and `pad_oe` therefore stay stable while the chain shifts or captures.
- R7: With `extest`=1, a three-bit pin drives `pad_o` from its output-bit latch and `pad_oe` from its enable-bit latch. An input-only pin always drives `pad_o`=0 and `pad_oe`=0.
- R8: With `extest`=0, a three-bit pin passes `core_o` and `core_oe` to its pad.
- R9: The bypass bit loads 0 on a capture strobe and `tdi` on a shift strobe. With `byp_sel`=1, `tdo` shows the bypass bit.
- R10: `core_i` always follows `pad_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dr_strobe | input | 1 | Data-register clock enable (capture or shift) |
| shift_sel | input | 1 | 1 = shift, 0 = capture |
| upd_strobe | input | 1 | Loads the update latches |
| extest | input | 1 | Pads driven from the update latches |
| byp_sel | input | 1 | 1 = bypass bit drives tdo |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| cap_t | input | 1 | Internal signal captured into bit 0 |
| cap_o | input | 1 | Internal signal captured into bit 1 |
| int_net | output | 1 | Internal net driven by the last bit's latch |
| core_o | input | NPIN | Core output value per pin |
| core_oe | input | NPIN | Core drive enable per pin |
| core_i | output | NPIN | Pad input value to the core |
| pad_i | input | NPIN | Pad input value |
| pad_o | output | NPIN | Pad output value |
| pad_oe | output | NPIN | Pad drive enable (0 = high impedance) |

## Verification
The chain is tried with three kinds of stimulus, each of which separates a different class of fault:
- A single capture of distinct internal, core and pad values, followed by a full shift-out, checks every bit position. This separates a wrong pin length or a swapped bit order from correct wiring.
- Pattern shifts followed by an update in external-test mode, including an update in the same cycle as a shift, show whether the latches take the value from before or after the shift, and whether the pads move during shifting.
- Long random mixes of capture, shift, update, bypass, mode changes and occasional resets, compared against a bench model, catch wrong bypass loading and a wrong mux choice between core and latch.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        PK_BIDIR = 2'd0,
        PK_IN    = 2'd1,
        PK_OUT   = 2'd2
    } pin_kind_e;

    typedef struct packed {
        logic dr_strobe;
        logic shift_sel;
        logic upd_strobe;
    } scan_ctl_t;

    localparam int POS_CAP_T = 0;
    localparam int POS_CAP_O = 1;
    localparam int OFS_IN    = 0;
    localparam int OFS_OUT   = 1;
    localparam int OFS_EN    = 2;

    function automatic int chain_len(int nb, int ni, int no);
        return 2 + 3 * nb + ni + 3 * no + 1;
    endfunction

    function automatic pin_kind_e kind_of(int p, int nb, int ni);
        if (p < nb)           return PK_BIDIR;
        else if (p < nb + ni) return PK_IN;
        else                  return PK_OUT;
    endfunction

    function automatic int pin_base(int p, int nb, int ni);
        if (p < nb)           return 2 + 3 * p;
        else if (p < nb + ni) return 2 + 3 * nb + (p - nb);
        else                  return 2 + 3 * nb + ni + 3 * (p - nb - ni);
    endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  scan_ctl_t ctl,
    input  logic      ser_in,
    input  logic      cap_in,
    output logic      q,
    output logic      upd
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ctl.dr_strobe)
            q <= ctl.shift_sel ? ser_in : cap_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            upd <= 1'b0;
        else if (ctl.upd_strobe)
            upd <= q;
    end
endmodule

// File: rtl/bsr_bypass.sv
module bsr_bypass
    import bsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  scan_ctl_t ctl,
    input  logic      tdi,
    output logic      q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ctl.dr_strobe)
            q <= ctl.shift_sel ? tdi : 1'b0;
    end
endmodule

// File: rtl/bsr_pin.sv
module bsr_pin
    import bsr_pkg::*;
#(
    parameter pin_kind_e KIND = PK_BIDIR
) (
    input  logic       extest,
    input  logic       core_o,
    input  logic       core_oe,
    input  logic       pad_i,
    input  logic       u_out,
    input  logic       u_en,
    output logic       pad_o,
    output logic       pad_oe,
    output logic [2:0] cap
);
    generate
        if (KIND == PK_IN) begin : g_in
            logic unused_in;
            assign unused_in = core_o ^ core_oe ^ u_out ^ u_en ^ extest;
            assign pad_o  = 1'b0;
            assign pad_oe = 1'b0;
            assign cap    = {2'b00, pad_i};
        end else begin : g_drv
            assign pad_o  = extest ? u_out : core_o;
            assign pad_oe = extest ? u_en  : core_oe;
            assign cap[OFS_IN]  = pad_i;
            assign cap[OFS_OUT] = core_o;
            assign cap[OFS_EN]  = core_oe;
        end
    endgenerate
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int N_BIDIR   = 2,
    parameter int N_INONLY  = 1,
    parameter int N_OUTONLY = 1,
    localparam int NPIN     = N_BIDIR + N_INONLY + N_OUTONLY
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dr_strobe,
    input  logic            shift_sel,
    input  logic            upd_strobe,
    input  logic            extest,
    input  logic            byp_sel,
    input  logic            tdi,
    output logic            tdo,
    input  logic            cap_t,
    input  logic            cap_o,
    output logic            int_net,
    input  logic [NPIN-1:0] core_o,
    input  logic [NPIN-1:0] core_oe,
    output logic [NPIN-1:0] core_i,
    input  logic [NPIN-1:0] pad_i,
    output logic [NPIN-1:0] pad_o,
    output logic [NPIN-1:0] pad_oe
);
    localparam int L = chain_len(N_BIDIR, N_INONLY, N_OUTONLY);

    scan_ctl_t      ctl;
    logic [L-1:0]   sq_q;
    logic [L-1:0]   upd_q;
    logic [L-1:0]   cap_v;
    logic [L-1:0]   ser_v;
    logic           byp_q;
    logic           unused_upd;

    assign ctl        = '{dr_strobe: dr_strobe, shift_sel: shift_sel, upd_strobe: upd_strobe};
    assign ser_v      = {tdi, sq_q[L-1:1]};
    assign unused_upd = ^upd_q;

    assign cap_v[POS_CAP_T] = cap_t;
    assign cap_v[POS_CAP_O] = cap_o;
    assign cap_v[L-1]       = upd_q[L-1];

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            localparam int        B = pin_base(p, N_BIDIR, N_INONLY);
            localparam pin_kind_e K = kind_of(p, N_BIDIR, N_INONLY);
            if (K == PK_IN) begin : g_one
                logic [2:0] unused_cap;
                bsr_pin #(.KIND(PK_IN)) u_pin (
                    .extest (extest),
                    .core_o (core_o[p]),
                    .core_oe(core_oe[p]),
                    .pad_i  (pad_i[p]),
                    .u_out  (1'b0),
                    .u_en   (1'b0),
                    .pad_o  (pad_o[p]),
                    .pad_oe (pad_oe[p]),
                    .cap    (unused_cap)
                );
                assign cap_v[B] = unused_cap[OFS_IN];
            end else begin : g_three
                logic [2:0] pc;
                bsr_pin #(.KIND(K)) u_pin (
                    .extest (extest),
                    .core_o (core_o[p]),
                    .core_oe(core_oe[p]),
                    .pad_i  (pad_i[p]),
                    .u_out  (upd_q[B+OFS_OUT]),
                    .u_en   (upd_q[B+OFS_EN]),
                    .pad_o  (pad_o[p]),
                    .pad_oe (pad_oe[p]),
                    .cap    (pc)
                );
                assign cap_v[B+2:B] = pc;
            end
        end

        for (genvar k = 0; k < L; k++) begin : g_bit
            bsr_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .ctl   (ctl),
                .ser_in(ser_v[k]),
                .cap_in(cap_v[k]),
                .q     (sq_q[k]),
                .upd   (upd_q[k])
            );
        end
    endgenerate

    bsr_bypass u_byp (
        .clk(clk),
        .rst(rst),
        .ctl(ctl),
        .tdi(tdi),
        .q  (byp_q)
    );

    assign tdo     = byp_sel ? byp_q : sq_q[0];
    assign int_net = upd_q[L-1];
    assign core_i  = pad_i;
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
    parameter int L    = 4,
    parameter int NPIN = 1
) (
    input logic            clk,
    input logic            rst,
    input logic            dr_strobe,
    input logic            shift_sel,
    input logic            upd_strobe,
    input logic            extest,
    input logic            byp_sel,
    input logic            tdi,
    input logic            tdo,
    input logic            cap_t,
    input logic            cap_o,
    input logic            int_net,
    input logic [NPIN-1:0] pad_o,
    input logic [NPIN-1:0] pad_oe,
    input logic [L-1:0]    sq
);
    // R1: after reset, the enables held in the latches are all off
    p_reset_hiz_r1: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && extest) |-> (pad_oe == '0 && int_net == 1'b0));

    // R3: the internal capture bits load their sources
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        $past(dr_strobe && !shift_sel && !rst) |-> (sq[0] == $past(cap_t) && sq[1] == $past(cap_o)));

    // R4: one position per shift strobe, tdi entering at the top
    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        $past(dr_strobe && shift_sel && !rst) |-> (sq[L-2:0] == $past(sq[L-1:1]) && sq[L-1] == $past(tdi)));

    // R5: internal net takes the last bit on update
    p_update_r5: assert property (@(posedge clk) disable iff (rst)
        $past(upd_strobe && !rst) |-> (int_net == $past(sq[L-1])));

    // R6: pads hold in external-test mode without an update
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!upd_strobe && !rst && extest) && extest) |-> ($stable(pad_o) && $stable(pad_oe)));

    // R9: bypass path carries tdi one shift later
    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(dr_strobe && shift_sel && !rst) && byp_sel) |-> (tdo == $past(tdi)));
endmodule

bind bsr_chain bsr_chain_chk #(.L(L), .NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dr_strobe (dr_strobe),
    .shift_sel (shift_sel),
    .upd_strobe(upd_strobe),
    .extest    (extest),
    .byp_sel   (byp_sel),
    .tdi       (tdi),
    .tdo       (tdo),
    .cap_t     (cap_t),
    .cap_o     (cap_o),
    .int_net   (int_net),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe),
    .sq        (sq_q)
);

// File: tb/sim_bsr_chain.sv
`timescale 1ns/1ps
module sim_bsr_chain;
    localparam int NB   = 2;
    localparam int NI   = 1;
    localparam int NO   = 1;
    localparam int NPIN = NB + NI + NO;
    localparam int L    = 2 + 3 * NB + NI + 3 * NO + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dr_strobe = 0, shift_sel = 0, upd_strobe = 0, extest = 0, byp_sel = 0;
    logic tdi = 0, cap_t = 0, cap_o = 0;
    logic [NPIN-1:0] core_o = '0, core_oe = '0, pad_i = '0;
    logic tdo, int_net;
    logic [NPIN-1:0] core_i, pad_o, pad_oe;

    always #4 clk = ~clk;

    bsr_chain #(.N_BIDIR(NB), .N_INONLY(NI), .N_OUTONLY(NO)) u0 (
        .clk(clk), .rst(rst), .dr_strobe(dr_strobe), .shift_sel(shift_sel),
        .upd_strobe(upd_strobe), .extest(extest), .byp_sel(byp_sel), .tdi(tdi),
        .tdo(tdo), .cap_t(cap_t), .cap_o(cap_o), .int_net(int_net),
        .core_o(core_o), .core_oe(core_oe), .core_i(core_i), .pad_i(pad_i),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [L-1:0] m_sq = '0;
    logic [L-1:0] m_u  = '0;
    logic         m_byp = 1'b0;
    logic         last_upd = 1'b0;
    int           base_of [NPIN];
    string        tag_ov = "";
    logic [31:0]  seed_dummy;

    function automatic bit is_in(int p);
        return (p >= NB) && (p < NB + NI);
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [L-1:0] cap_vec();
        logic [L-1:0] c;
        c = '0;
        c[0] = cap_t;
        c[1] = cap_o;
        for (int p = 0; p < NPIN; p++) begin
            c[base_of[p]] = pad_i[p];
            if (!is_in(p)) begin
                c[base_of[p] + 1] = core_o[p];
                c[base_of[p] + 2] = core_oe[p];
            end
        end
        c[L-1] = m_u[L-1];
        return c;
    endfunction

    // inputs are already set; sample before the edge, then advance the model
    task automatic cyc();
        logic [NPIN-1:0] eo, ee;
        logic [L-1:0] old;
        #2;
        for (int p = 0; p < NPIN; p++) begin
            if (is_in(p)) begin
                eo[p] = 1'b0; ee[p] = 1'b0;
            end else if (extest) begin
                eo[p] = m_u[base_of[p] + 1]; ee[p] = m_u[base_of[p] + 2];
            end else begin
                eo[p] = core_o[p]; ee[p] = core_oe[p];
            end
        end
        if (!rst) begin
            chk(tag_ov != "" ? tag_ov : (byp_sel ? "R9" : "R4"), tdo,
                byp_sel ? m_byp : m_sq[0], "tdo");
            chk("R5", int_net, m_u[L-1], "int_net");
            chk(!extest ? "R8" : (last_upd ? "R7" : "R6"), pad_o, eo, "pad_o");
            chk(!extest ? "R8" : (last_upd ? "R7" : "R6"), pad_oe, ee, "pad_oe");
            chk("R10", core_i, pad_i, "core_i");
        end
        @(posedge clk);
        old = m_sq;
        if (rst) begin
            m_sq = '0; m_u = '0; m_byp = 1'b0;
        end else begin
            if (dr_strobe) begin
                if (shift_sel) begin
                    m_sq  = {tdi, old[L-1:1]};
                    m_byp = tdi;
                end else begin
                    m_sq  = cap_vec();
                    m_byp = 1'b0;
                end
            end
            if (upd_strobe) m_u = old;
        end
        last_upd = upd_strobe & ~rst;
        @(negedge clk);
    endtask

    task automatic set_ctl(logic d, logic s, logic u, logic e, logic b);
        dr_strobe = d; shift_sel = s; upd_strobe = u; extest = e; byp_sel = b;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int pos;
        logic [L-1:0] pat;
        seed_dummy = $urandom(32'd2024);
        pos = 2;
        for (int p = 0; p < NPIN; p++) begin
            base_of[p] = pos;
            pos += is_in(p) ? 1 : 3;
        end

        // R1: reset state
        @(negedge clk);
        set_ctl(0, 0, 0, 1, 0);
        core_o = '1; core_oe = '1;
        for (int i = 0; i < 3; i++) cyc();
        rst = 1'b0;
        #2;
        chk("R1", pad_oe, '0, "pad_oe after reset");
        chk("R1", int_net, 0, "int_net after reset");
        chk("R1", tdo, 0, "tdo after reset");
        cyc();

        // R3 and R2: capture distinct values, then shift the whole chain out
        set_ctl(1, 0, 0, 0, 0);
        cap_t = 1; cap_o = 0;
        core_o = 4'b1010; core_oe = 4'b0110; pad_i = 4'b1101;
        cyc();
        set_ctl(0, 0, 0, 0, 0);
        #2;
        chk("R3", tdo, 1, "bit0 holds cap_t");
        cyc();
        tag_ov = "R2";
        set_ctl(1, 1, 0, 0, 0);
        for (int i = 0; i < L; i++) begin
            tdi = i[0];
            cyc();
        end
        tag_ov = "";

        // R5, R7: shift a pattern in, update, then drive from latches
        pat = L'($urandom);
        for (int i = 0; i < L; i++) begin
            set_ctl(1, 1, 0, 1, 0);
            tdi = pat[i];
            cyc();
        end
        set_ctl(0, 0, 1, 1, 0);
        cyc();
        set_ctl(0, 0, 0, 1, 0);
        cyc();
        // R6: shifting in external-test mode leaves pads unchanged
        for (int i = 0; i < 5; i++) begin
            set_ctl(1, 1, 0, 1, 0);
            tdi = ~tdi;
            cyc();
        end
        // R5: update in the same cycle as a shift takes the pre-shift value
        set_ctl(1, 1, 1, 1, 0);
        tdi = 1;
        cyc();
        set_ctl(0, 0, 0, 1, 0);
        cyc();

        // R9: bypass capture then shift
        set_ctl(1, 0, 0, 0, 1);
        cyc();
        set_ctl(1, 1, 0, 0, 1);
        tdi = 1;
        cyc();
        set_ctl(0, 0, 0, 0, 1);
        cyc();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            rst = ($urandom % 300) == 0;
            dr_strobe  = $urandom % 2;
            shift_sel  = ($urandom % 4) != 0;
            upd_strobe = ($urandom % 5) == 0;
            if (($urandom % 16) == 0) extest = ~extest;
            byp_sel = ($urandom % 6) == 0;
            tdi = $urandom % 2;
            cap_t = $urandom % 2;
            cap_o = $urandom % 2;
            core_o = NPIN'($urandom);
            core_oe = NPIN'($urandom);
            pad_i = NPIN'($urandom);
            cyc();
        end
        rst = 0;

        summary();
        $finish;
    end
endmodule